// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block takes one received Ethernet frame and stores it in a page of packet memory. The frame arrives in two steps. First a descriptor gives the frame length in bytes. Then the payload follows as a stream, one byte per cycle, under a valid/ready handshake. When the descriptor is accepted, the block checks whether the frame can be taken and claims a free page from the page allocator.

The page is then written through a single byte-wide write port, one byte per cycle, in this order:
- a 16-bit status word;
- a 16-bit stored byte count;
- the even part of the frame data, zero-padded up to the minimum frame size;
- an optional CRC-32 of the stored frame;
- a two-byte trailer that holds the odd last byte, if any, and a control code.

When the last byte is written, the page number goes onto the receive queue and the receive interrupt pulses. A frame that is refused is still drained from the byte stream, so the stream stays aligned with the descriptors, and a drop pulse is given.

Top module: `rxbuf_writer`

## Requirements
- R1: A frame whose descriptor is accepted while `rx_enable` is 0 or `soft_reset` is 1 is refused. All of its `start_len` bytes are consumed, nothing is written, no page is claimed, and `frame_drop` pulses once after the last byte (or in the cycle after acceptance when the length is 0).
- R2: The stored count is computed in three steps. Take E = 64 if the length is below 64, otherwise the length rounded down to even. Add 6. Add 4 more when `strip_crc` is 0. If the count exceeds 2048, the frame is refused as in R1. Otherwise the count is written little-endian at page offsets 2 and 3.
- R3: If `alloc_avail` is 0 when the descriptor is accepted, the frame is refused as in R1 and `alloc_take` stays low. Otherwise `alloc_take` pulses once before the first write, and every write of that frame goes to the page that `alloc_page` held at acceptance.
- R4: The status word is written little-endian at offsets 0 and 1. Bit 11 is set when the length exceeds 1518, bit 12 is set when the length is odd, and all other bits are 0.
- R5: Frame byte i is written at offset 4+i, at consecutive addresses, one write per cycle. The single exception is the last byte of an odd frame of 64 bytes or more.
- R6: For a frame shorter than 64 bytes, every byte is written in place, including an odd last byte. Offsets 4+length up to 67 are then written with 0.
- R7: When `strip_crc` is 0, the four CRC bytes are written least significant first at offsets 4+E up to 7+E. The CRC is CRC-32 with reflected polynomial 0xEDB88320, all-ones preset and final inversion. It is computed over the frame bytes, plus the zero padding for short frames.
- R8: The two trailer bytes follow directly. For an odd frame of 64 bytes or more they are the last frame byte, then 0x60. For any other frame they are 0x00, then 0x40.
- R9: One cycle after the last trailer write, `rxq_push` and `rcv_irq` pulse together for one cycle, with `rxq_page` equal to the claimed page. This happens exactly once per stored frame.
- R10: `in_ready` is high only while frame bytes are being taken, stored or drained. It is low during the header, padding, CRC and trailer phases.
- R11: `start_ready` is high only while the block is idle, so a new descriptor is never accepted while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enabled, sampled at descriptor acceptance |
| soft_reset | input | 1 | Soft reset active, refuses frames |
| strip_crc | input | 1 | 1: no CRC stored |
| start_valid | input | 1 | Descriptor valid |
| start_len | input | LEN_W | Frame length in bytes |
| start_ready | output | 1 | Descriptor accepted when high with start_valid |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Frame byte taken when high with in_valid |
| alloc_avail | input | 1 | A free page exists |
| alloc_page | input | PAGE_W | Number of the free page |
| alloc_take | output | 1 | Pulse: offered page claimed |
| wr_en | output | 1 | Packet memory write strobe |
| wr_page | output | PAGE_W | Page written |
| wr_addr | output | ADDR_W | Byte offset in page |
| wr_data | output | 8 | Byte written |
| rxq_push | output | 1 | Push page onto receive queue |
| rxq_page | output | PAGE_W | Page pushed |
| rcv_irq | output | 1 | Receive interrupt set pulse |
| frame_drop | output | 1 | Pulse: frame refused and drained |

## Verification
The bench uses the default parameters: 2048-byte pages, four pages, 12-bit lengths, a 64-byte minimum and a 1518-byte limit. These values put the 2048-byte refusal threshold within reach of a 2041-byte frame. They also allow both status bits, the short-frame padding with an odd byte in place, the odd-trailer layout and a zero-length frame.

The frame patterns cover CRC on and off, and the three refusal causes: receive disabled or soft reset, oversize, and no free page.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_PAD, S_CRC, S_TRL, S_DONE, S_DRAIN
  } wr_state_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxbuf_crc32.sv
module rxbuf_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  import rxbuf_pkg::*;

  logic [31:0] crc_q, crc_n;

  always_comb begin
    crc_n = crc_q;
    if (clr)      crc_n = 32'hFFFF_FFFF;
    else if (upd) crc_n = crc32_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else        crc_q <= crc_n;
  end

  assign crc_out = ~crc_q;
endmodule

// File: rtl/rxbuf_len_calc.sv
module rxbuf_len_calc #(
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_GOOD   = 1518
) (
  input  logic [LEN_W-1:0] len,
  input  logic             strip,
  output logic [15:0]      stored,
  output logic [15:0]      status,
  output logic             too_big,
  output logic             short_frame,
  output logic             odd_tail
);
  localparam int SUM_W = LEN_W + 2;

  logic [SUM_W-1:0] eff, total;

  always_comb begin
    short_frame = (int'(len) < MIN_FRAME);
    eff         = short_frame ? SUM_W'(MIN_FRAME) : SUM_W'({len[LEN_W-1:1], 1'b0});
    total       = eff + SUM_W'(6) + (strip ? SUM_W'(0) : SUM_W'(4));
    too_big     = (int'(total) > PAGE_BYTES);
    stored      = 16'(total);
    status      = 16'd0;
    status[11]  = (int'(len) > MAX_GOOD);
    status[12]  = len[0];
    odd_tail    = len[0] && !short_frame;
  end
endmodule

// File: rtl/rxbuf_writer.sv
module rxbuf_writer #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 2,
  parameter int LEN_W     = 12,
  parameter int MIN_FRAME = 64,
  parameter int MAX_GOOD  = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              soft_reset,
  input  logic              strip_crc,
  input  logic              start_valid,
  input  logic [LEN_W-1:0]  start_len,
  output logic              start_ready,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              alloc_avail,
  input  logic [PAGE_W-1:0] alloc_page,
  output logic              alloc_take,
  output logic              wr_en,
  output logic [PAGE_W-1:0] wr_page,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rxq_push,
  output logic [PAGE_W-1:0] rxq_page,
  output logic              rcv_irq,
  output logic              frame_drop
);
  import rxbuf_pkg::*;

  localparam int PAGE_BYTES = 1 << ADDR_W;
  localparam int HDR_BYTES  = 4;
  localparam logic [ADDR_W-1:0] PAD_LAST = ADDR_W'(HDR_BYTES + MIN_FRAME - 1);

  wr_state_t         st_q, st_n;
  logic [LEN_W-1:0]  len_q, len_n, cnt_q, cnt_n;
  logic [1:0]        sub_q, sub_n;
  logic [ADDR_W-1:0] wptr_q, wptr_n;
  logic [PAGE_W-1:0] page_q, page_n;
  logic              crc_en_q, crc_en_n;
  logic [7:0]        odd_q, odd_n;
  logic              we_n, take_n, push_n, drop_n;
  logic [ADDR_W-1:0] wa_n;
  logic [7:0]        wd_n;
  logic              we_q, take_q, push_q, drop_q;
  logic [ADDR_W-1:0] wa_q;
  logic [7:0]        wd_q;

  logic              crc_clr, crc_upd;
  logic [7:0]        crc_din;
  logic [31:0]       crc_val;

  logic [LEN_W-1:0]  calc_len;
  logic              calc_strip;
  logic [15:0]       stored, status;
  logic              too_big, short_frame, odd_tail;
  logic              last_byte, refuse;

  assign calc_len   = (st_q == S_IDLE) ? start_len : len_q;
  assign calc_strip = (st_q == S_IDLE) ? strip_crc : !crc_en_q;

  rxbuf_len_calc #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MIN_FRAME(MIN_FRAME), .MAX_GOOD(MAX_GOOD)
  ) u_len (
    .len(calc_len), .strip(calc_strip), .stored(stored), .status(status),
    .too_big(too_big), .short_frame(short_frame), .odd_tail(odd_tail)
  );

  rxbuf_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd), .din(crc_din), .crc_out(crc_val)
  );

  assign start_ready = (st_q == S_IDLE);
  assign in_ready    = (st_q == S_DATA) || (st_q == S_DRAIN);
  assign last_byte   = (cnt_q == len_q - LEN_W'(1));
  assign refuse      = !rx_enable || soft_reset || too_big || !alloc_avail;

  always_comb begin
    st_n = st_q; len_n = len_q; cnt_n = cnt_q; sub_n = sub_q; wptr_n = wptr_q;
    page_n = page_q; crc_en_n = crc_en_q; odd_n = odd_q;
    we_n = 1'b0; wa_n = wptr_q; wd_n = 8'd0; take_n = 1'b0; push_n = 1'b0; drop_n = 1'b0;
    crc_clr = 1'b0; crc_upd = 1'b0; crc_din = in_data;
    case (st_q)
      S_IDLE: if (start_valid) begin
        len_n = start_len; cnt_n = '0; sub_n = '0; wptr_n = '0;
        crc_clr = 1'b1; crc_en_n = !strip_crc; page_n = alloc_page;
        if (refuse) begin
          if (start_len == '0) drop_n = 1'b1;
          else                 st_n = S_DRAIN;
        end else begin
          take_n = 1'b1; st_n = S_HDR;
        end
      end
      S_HDR: begin
        we_n = 1'b1; wptr_n = wptr_q + ADDR_W'(1); sub_n = sub_q + 2'd1;
        case (sub_q)
          2'd0:    wd_n = status[7:0];
          2'd1:    wd_n = status[15:8];
          2'd2:    wd_n = stored[7:0];
          default: wd_n = stored[15:8];
        endcase
        if (sub_q == 2'd3) st_n = (len_q == '0) ? S_PAD : S_DATA;
      end
      S_DATA: if (in_valid) begin
        crc_upd = 1'b1; cnt_n = cnt_q + LEN_W'(1);
        if (odd_tail && last_byte) begin
          odd_n = in_data;
        end else begin
          we_n = 1'b1; wd_n = in_data; wptr_n = wptr_q + ADDR_W'(1);
        end
        if (last_byte) begin
          sub_n = '0;
          st_n  = short_frame ? S_PAD : (crc_en_q ? S_CRC : S_TRL);
        end
      end
      S_PAD: begin
        we_n = 1'b1; crc_upd = 1'b1; crc_din = 8'd0; wptr_n = wptr_q + ADDR_W'(1);
        if (wptr_q == PAD_LAST) st_n = crc_en_q ? S_CRC : S_TRL;
      end
      S_CRC: begin
        we_n = 1'b1; wd_n = crc_val[8*sub_q +: 8];
        wptr_n = wptr_q + ADDR_W'(1); sub_n = sub_q + 2'd1;
        if (sub_q == 2'd3) st_n = S_TRL;
      end
      S_TRL: begin
        we_n = 1'b1; wptr_n = wptr_q + ADDR_W'(1); sub_n = sub_q + 2'd1;
        if (sub_q == 2'd0) wd_n = odd_tail ? odd_q : 8'h00;
        else               wd_n = odd_tail ? 8'h60 : 8'h40;
        if (sub_q == 2'd1) st_n = S_DONE;
      end
      S_DONE: begin
        push_n = 1'b1; st_n = S_IDLE;
      end
      S_DRAIN: if (in_valid) begin
        cnt_n = cnt_q + LEN_W'(1);
        if (last_byte) begin
          drop_n = 1'b1; st_n = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; len_q <= '0; cnt_q <= '0; sub_q <= '0; wptr_q <= '0;
      page_q <= '0; crc_en_q <= 1'b0; odd_q <= 8'd0;
      we_q <= 1'b0; wa_q <= '0; wd_q <= 8'd0;
      take_q <= 1'b0; push_q <= 1'b0; drop_q <= 1'b0;
    end else begin
      st_q <= st_n; len_q <= len_n; cnt_q <= cnt_n; sub_q <= sub_n; wptr_q <= wptr_n;
      page_q <= page_n; crc_en_q <= crc_en_n; odd_q <= odd_n;
      we_q <= we_n; wa_q <= wa_n; wd_q <= wd_n;
      take_q <= take_n; push_q <= push_n; drop_q <= drop_n;
    end
  end

  assign wr_en      = we_q;
  assign wr_addr    = wa_q;
  assign wr_data    = wd_q;
  assign wr_page    = page_q;
  assign alloc_take = take_q;
  assign rxq_push   = push_q;
  assign rxq_page   = page_q;
  assign rcv_irq    = push_q;
  assign frame_drop = drop_q;
endmodule

// File: rtl/rxbuf_writer_chk.sv
module rxbuf_writer_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              rxq_push,
  input logic              rcv_irq,
  input logic              frame_drop,
  input logic              alloc_take,
  input logic              alloc_avail,
  input logic              start_ready,
  input logic              in_ready
);
  assert_drop_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> !wr_en);

  assert_take_needs_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_take |-> $past(alloc_avail));

  assert_status_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0)) |-> (wr_data[7:0] == 8'd0));

  assert_wr_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  assert_push_after_trailer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |-> ($past(wr_en) && ($past(wr_data) == 8'h40 || $past(wr_data) == 8'h60)));

  assert_push_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |=> !rxq_push);

  assert_push_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |-> (rcv_irq && !wr_en));

  assert_ready_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !start_ready);
endmodule

bind rxbuf_writer rxbuf_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rxq_push(rxq_push), .rcv_irq(rcv_irq), .frame_drop(frame_drop),
  .alloc_take(alloc_take), .alloc_avail(alloc_avail),
  .start_ready(start_ready), .in_ready(in_ready)
);

// File: tb/rxbuf_writer_tb.sv
module rxbuf_writer_tb;
  localparam int K_TAKE = 0, K_WR = 1, K_PUSH = 2, K_DROP = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_enable, soft_reset, strip_crc, start_valid, in_valid, alloc_avail;
  logic [11:0] start_len;
  logic [7:0]  in_data;
  logic [1:0]  alloc_page;
  logic start_ready, in_ready, alloc_take, wr_en, rxq_push, rcv_irq, frame_drop;
  logic [1:0]  wr_page, rxq_page;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;

  int n_checks = 0, n_fail = 0, exp_page = 0;
  int kq[$], aq[$], dq[$];
  string tq[$];
  logic [7:0] fb [0:2047];

  always #10 clk = ~clk;

  rxbuf_writer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .soft_reset(soft_reset),
    .strip_crc(strip_crc), .start_valid(start_valid), .start_len(start_len),
    .start_ready(start_ready), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .alloc_avail(alloc_avail), .alloc_page(alloc_page), .alloc_take(alloc_take),
    .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
    .rxq_push(rxq_push), .rxq_page(rxq_page), .rcv_irq(rcv_irq), .frame_drop(frame_drop)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int k, input int a, input int d, input string tag);
    kq.push_back(k); aq.push_back(a); dq.push_back(d); tq.push_back(tag);
  endtask

  task automatic pop_cmp(input int k, input int a, input int d);
    int ek, ea, ed;
    string et;
    if (kq.size() == 0) begin
      check(1'b0, "R9 unexpected output event", k, -1);
      return;
    end
    ek = kq.pop_front(); ea = aq.pop_front(); ed = dq.pop_front(); et = tq.pop_front();
    check(ek == k, {et, " event kind"}, k, ek);
    check(ea == a, {et, " addr/page"}, a, ea);
    check(ed == d, {et, " data"}, d, ed);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (alloc_take) pop_cmp(K_TAKE, 0, 0);
      if (wr_en) begin
        check(int'(wr_page) == exp_page, "R3 write page", int'(wr_page), exp_page);
        pop_cmp(K_WR, int'(wr_addr), int'(wr_data));
      end
      if (rxq_push) pop_cmp(K_PUSH, int'(rxq_page), int'(rcv_irq));
      if (frame_drop) pop_cmp(K_DROP, 0, 0);
    end
  end

  task automatic send_frame(input int len, input int seed, input int page, input bit avail,
                            input bit en, input bit srst, input bit strip, input string dtag);
    int eff, stored, st, p;
    bit drop, oddt;
    logic [31:0] c;
    for (int i = 0; i < len; i++) fb[i] = 8'(seed + i * 7 + (i >> 3));
    eff    = (len < 64) ? 64 : (len & ~1);
    stored = eff + 6 + (strip ? 0 : 4);
    drop   = !en || srst || (stored > 2048) || !avail;
    oddt   = (len >= 64) && (len % 2 == 1);
    if (drop) begin
      push_exp(K_DROP, 0, 0, dtag);
    end else begin
      exp_page = page;
      push_exp(K_TAKE, 0, 0, "R3");
      st = ((len > 1518) ? 32'h0800 : 0) | ((len % 2 == 1) ? 32'h1000 : 0);
      push_exp(K_WR, 0, st & 255, "R4");
      push_exp(K_WR, 1, st >> 8, "R4");
      push_exp(K_WR, 2, stored & 255, "R2");
      push_exp(K_WR, 3, stored >> 8, "R2");
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < eff || i < len; i++) begin
        logic [7:0] b;
        b = (i < len) ? fb[i] : 8'd0;
        if (!(oddt && i == len - 1)) push_exp(K_WR, 4 + i, b, (i < len) ? "R5" : "R6");
        c = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      c = ~c;
      p = 4 + eff;
      if (!strip) begin
        for (int k = 0; k < 4; k++) push_exp(K_WR, p + k, (c >> (8 * k)) & 255, "R7");
        p += 4;
      end
      push_exp(K_WR, p, oddt ? fb[len - 1] : 0, "R8");
      push_exp(K_WR, p + 1, oddt ? 8'h60 : 8'h40, "R8");
      push_exp(K_PUSH, page, 1, "R9");
    end
    @(negedge clk);
    rx_enable = en; soft_reset = srst; strip_crc = strip; alloc_avail = avail;
    alloc_page = 2'(page); start_len = 12'(len); start_valid = 1'b1;
    while (!start_ready) @(negedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    if (!drop && len > 0)
      check(!in_ready && !start_ready, "R10 R11 no byte or descriptor in header", in_ready, 0);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = fb[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int w = 0; w < 300 && kq.size() != 0; w++) @(negedge clk);
    check(kq.size() == 0, "R9 all expected events seen", kq.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_enable = 1'b0; soft_reset = 1'b0; strip_crc = 1'b0;
    start_valid = 1'b0; start_len = '0; in_valid = 1'b0; in_data = '0;
    alloc_avail = 1'b0; alloc_page = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_en && !rxq_push && !frame_drop && !alloc_take, "R9 reset outputs idle",
          {wr_en, rxq_push, frame_drop, alloc_take}, 0);
    check(start_ready && !in_ready, "R11 ready after reset", {start_ready, in_ready}, 2);

    send_frame(61,   3, 2, 1, 1, 0, 0, "");
    send_frame(100,  9, 1, 1, 1, 0, 1, "");
    send_frame(71,  17, 3, 1, 1, 0, 0, "");
    send_frame(1519, 5, 0, 1, 1, 0, 1, "");
    send_frame(0,    1, 1, 1, 1, 0, 1, "");
    send_frame(5,    2, 0, 1, 0, 0, 0, "R1");
    send_frame(12,   4, 0, 1, 1, 1, 0, "R1");
    send_frame(0,    4, 0, 1, 0, 0, 0, "R1");
    send_frame(8,    6, 2, 0, 1, 0, 0, "R3");
    send_frame(2041, 8, 1, 1, 1, 0, 0, "R2");
    send_frame(2041, 8, 3, 1, 1, 0, 1, "");
    send_frame(64,  11, 2, 1, 1, 0, 0, "");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule